// File: doc/BRIEF.md
# Region-Aware Word Address Counter

This block keeps the internal byte pointer of a serial nonvolatile memory front end. It holds a 15-bit word address that survives from one bus transaction to the next. It also remembers which storage region was selected last. A protocol decoder, which sits outside this block, loads a start address together with a region code. After each data byte, the decoder pulses an increment strobe and marks the byte as a write or a read.

Where the pointer wraps depends on the region and on the direction of access:
- Main-array writes stay inside the current 64-byte page.
- Main-array reads run across the whole 32 KB array and roll from the top back to zero.
- The 64-byte protected sector wraps on its own 6-bit offset.
- The 16-byte identifier wraps on its own 4-bit offset.
- A one-byte lock/status region never advances, so the same byte is presented again and again.

Because the pointer is retained, a later read that gives no address starts at the byte after the last one handled.

Top module: `word_addr_counter`

## Requirements
- R1: After reset the address output is 0 and the selected region is the main array.
- R2: A load with region code 0 (main array) puts all 15 bits of the given address on the output in the next cycle.
- R3: In the main array, a write increment advances only address bits [5:0], so offset 0x3F returns to offset 0x00 of the same page. Bits [14:6] never change. More than 64 writes therefore revisit the page in arrival order.
- R4: In the main array, a read increment adds one to the full 15-bit address, carrying across page edges, and 0x7FFF becomes 0x0000.
- R5: A load with region code 1 (protected sector) keeps only address bits [5:0] and clears the rest. Increments in either direction step that offset and wrap from 0x3F to 0x00.
- R6: A load with region code 2 (identifier) keeps only address bits [3:0] and clears the rest. Increments in either direction wrap from 0xF to 0x0.
- R7: A load with region code 3 (lock/status) keeps the full address. Increments then leave the address unchanged.
- R8: With neither load nor increment, the address and the selected region hold, so a later increment continues from the retained value.
- R9: When load and increment are asserted in the same cycle, the load wins and the increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Load the address and region |
| loadAddr | input | 15 | Address to load |
| loadRegion | input | 2 | Region code: 0 main, 1 protected sector, 2 identifier, 3 lock/status |
| incEn | input | 1 | Advance after a data byte |
| incIsWrite | input | 1 | 1 when the byte was a write, 0 when it was a read |
| curAddr | output | 15 | Current word address |

## Verification
The bench aims at the corner cases listed below; each shows up directly on `curAddr`.
- Main-array writes that cross a page edge, including a run of 70 writes. A counter with one fixed modulus would spill into the next page instead of wrapping.
- Main-array reads at 0x0FFF and at 0x7FFF. A design that wraps reads within a page would fail at 0x0FFF, and a wrong top-end wrap would fail at 0x7FFF.
- Protected-sector and identifier offsets driven to their last value. A design that masks with the wrong width would either carry into upper bits or wrap early.
- Increments in the lock region, idle stretches, and a load in the same cycle as an increment. These catch a pointer that creeps or drifts, and a load/increment priority that is the wrong way round.

// File: rtl/wac_pkg.sv
package wac_pkg;
  typedef enum logic [1:0] {
    REG_MAIN = 2'd0,
    REG_SEC  = 2'd1,
    REG_UID  = 2'd2,
    REG_FIX  = 2'd3
  } regionE;

  typedef enum logic [2:0] {
    FLD_FULL = 3'd0,
    FLD_PAGE = 3'd1,
    FLD_SEC  = 3'd2,
    FLD_UID  = 3'd3,
    FLD_NONE = 3'd4
  } fieldE;

  typedef struct packed {
    logic  load;
    logic  advance;
    fieldE field;
  } strobeT;
endpackage

// File: rtl/wac_ctrl.sv
module wac_ctrl
  import wac_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadEn,
  input  logic [1:0] loadRegion,
  input  logic       incEn,
  input  logic       incIsWrite,
  output strobeT     strobe
);
  regionE curRegion;
  regionE newRegion;
  fieldE  stepField;
  fieldE  loadField;

  assign newRegion = regionE'(loadRegion);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       curRegion <= REG_MAIN;
    else if (loadEn) curRegion <= newRegion;
  end

  // Field that governs the loaded value
  always_comb begin
    unique case (newRegion)
      REG_SEC: loadField = FLD_SEC;
      REG_UID: loadField = FLD_UID;
      default: loadField = FLD_FULL;
    endcase
  end

  // Field that governs an increment in the stored region
  always_comb begin
    unique case (curRegion)
      REG_MAIN: stepField = incIsWrite ? FLD_PAGE : FLD_FULL;
      REG_SEC:  stepField = FLD_SEC;
      REG_UID:  stepField = FLD_UID;
      default:  stepField = FLD_NONE;
    endcase
  end

  always_comb begin
    strobe.load    = loadEn;
    strobe.advance = incEn && !loadEn && (stepField != FLD_NONE);
    strobe.field   = loadEn ? loadField : stepField;
  end

  a_r9_load_blocks_step: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |-> !strobe.advance);
endmodule

// File: rtl/wac_datapath.sv
module wac_datapath
  import wac_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6,
  parameter int SEC_W  = 6,
  parameter int UID_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [ADDR_W-1:0] loadAddr,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] PAGE_M = ADDR_W'((1 << PAGE_W) - 1);
  localparam logic [ADDR_W-1:0] SEC_M  = ADDR_W'((1 << SEC_W) - 1);
  localparam logic [ADDR_W-1:0] UID_M  = ADDR_W'((1 << UID_W) - 1);

  logic [ADDR_W-1:0] stepMask;
  logic [ADDR_W-1:0] loadMask;
  logic [ADDR_W-1:0] bumped;
  logic [ADDR_W-1:0] stepped;

  always_comb begin
    unique case (strobe.field)
      FLD_PAGE: stepMask = PAGE_M;
      FLD_SEC:  stepMask = SEC_M;
      FLD_UID:  stepMask = UID_M;
      FLD_NONE: stepMask = '0;
      default:  stepMask = '1;
    endcase
  end

  always_comb begin
    unique case (strobe.field)
      FLD_SEC: loadMask = SEC_M;
      FLD_UID: loadMask = UID_M;
      default: loadMask = '1;
    endcase
  end

  assign bumped  = addr + ADDR_W'(1);
  assign stepped = (addr & ~stepMask) | (bumped & stepMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               addr <= '0;
    else if (strobe.load)    addr <= loadAddr & loadMask;
    else if (strobe.advance) addr <= stepped;
  end

  a_r3_page_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && strobe.field == FLD_PAGE) |=>
      addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));
  a_r4_read_moves: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && strobe.field == FLD_FULL) |=> addr != $past(addr));
  a_r5_sec_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && strobe.field == FLD_SEC) |=> addr[ADDR_W-1:SEC_W] == '0);
  a_r6_uid_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && strobe.field == FLD_UID) |=> addr[ADDR_W-1:UID_W] == '0);
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.advance) |=> $stable(addr));
endmodule

// File: rtl/word_addr_counter.sv
module word_addr_counter
  import wac_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6,
  parameter int SEC_W  = 6,
  parameter int UID_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [1:0]        loadRegion,
  input  logic              incEn,
  input  logic              incIsWrite,
  output logic [ADDR_W-1:0] curAddr
);
  strobeT strobe;

  wac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadRegion(loadRegion),
    .incEn(incEn), .incIsWrite(incIsWrite), .strobe(strobe)
  );

  wac_datapath #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SEC_W(SEC_W), .UID_W(UID_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadAddr(loadAddr), .addr(curAddr)
  );

  a_r9_load_low_bits: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> curAddr[UID_W-1:0] == $past(loadAddr[UID_W-1:0]));
endmodule

// File: tb/tb_word_addr_counter.sv
`timescale 1ns/100ps
module tb_word_addr_counter;
  logic        clk = 0;
  logic        rstN = 0;
  logic        loadEn = 0;
  logic [14:0] loadAddr = '0;
  logic [1:0]  loadRegion = '0;
  logic        incEn = 0;
  logic        incIsWrite = 0;
  logic [14:0] curAddr;

  int nChecks = 0;
  int nFails  = 0;
  int mAddr   = 0;
  int mReg    = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  word_addr_counter dut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadRegion(loadRegion), .incEn(incEn), .incIsWrite(incIsWrite),
    .curAddr(curAddr)
  );

  task automatic check(input string req, input int expv);
    nChecks++;
    if (int'(curAddr) != expv) begin
      nFails++;
      $display("FAIL %s: curAddr=0x%04h expected=0x%04h", req, curAddr, expv);
    end
  endtask

  // One clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic cyc(input string req, input bit ld, input int a, input int rg,
                     input bit inc, input bit wr);
    loadEn = ld; loadAddr = 15'(a); loadRegion = 2'(rg);
    incEn = inc; incIsWrite = wr;
    @(posedge clk);
    if (ld) begin
      mReg = rg;
      if (rg == 1)      mAddr = a % 64;
      else if (rg == 2) mAddr = a % 16;
      else              mAddr = a % 32768;
    end else if (inc) begin
      case (mReg)
        0: mAddr = wr ? (mAddr / 64) * 64 + (mAddr % 64 + 1) % 64
                      : (mAddr + 1) % 32768;
        1: mAddr = (mAddr + 1) % 64;
        2: mAddr = (mAddr + 1) % 16;
        default: ;
      endcase
    end
    @(negedge clk);
    check(req, mAddr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1", 0);
    cyc("R1", 0, 0, 0, 1, 0);                  // read inc from reset: main region
    cyc("R2", 1, 'h1234, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc("R3", 0, 0, 0, 1, 1);
    cyc("R2", 1, 'h12BE, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc("R3", 0, 0, 0, 1, 1);   // 0x12BF -> 0x1280
    cyc("R2", 1, 'h0547, 0, 0, 0);
    for (int i = 0; i < 70; i++) cyc("R3", 0, 0, 0, 1, 1);  // over-length page write
    cyc("R2", 1, 'h0FFF, 0, 0, 0);
    cyc("R4", 0, 0, 0, 1, 0);                                // carry into next page
    cyc("R2", 1, 'h7FFE, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc("R4", 0, 0, 0, 1, 0);   // 0x7FFF -> 0
    cyc("R5", 1, 'h7FFD, 1, 0, 0);
    for (int i = 0; i < 2; i++) cyc("R5", 0, 0, 0, 1, 1);
    for (int i = 0; i < 3; i++) cyc("R5", 0, 0, 0, 1, 0);
    cyc("R6", 1, 'h00FE, 2, 0, 0);
    cyc("R6", 0, 0, 0, 1, 1);
    for (int i = 0; i < 3; i++) cyc("R6", 0, 0, 0, 1, 0);
    cyc("R7", 1, 'h0123, 3, 0, 0);
    cyc("R7", 0, 0, 0, 1, 1);
    for (int i = 0; i < 3; i++) cyc("R7", 0, 0, 0, 1, 0);
    cyc("R2", 1, 'h2A3F, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc("R8", 0, 'h1111, 2, 0, 1);
    cyc("R8", 0, 0, 0, 1, 1);                                // continues from 0x2A3F
    cyc("R9", 1, 'h0010, 1, 1, 0);                           // load wins
    cyc("R9", 1, 'h00AF, 2, 1, 1);
    cyc("R9", 0, 0, 0, 1, 0);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule